// File: doc/BRIEF.md
# Two-Point Oscillator Trim Calculator

This block works out the trim code that brings a target's internal oscillator to a desired rate. The target is programmed twice, once at its fastest trim setting and once at its slowest. Each time, the target produces a stream of pulses, and this block measures their timing in system clock ticks. A start strobe begins each measurement. A select input says which of the two trim points the pulses belong to. A mode input says how a time element is measured. In calibration-pulse mode, a time element is the interval from one rising edge to the next. In preamble mode, a time element is the width of one high pulse.

Each point is measured as the floor-average of 2^AVG_LOG2 consecutive elements. The average needs only a shift, not a divider. The two averages are kept as period values. Once both points are held, the block compares them with the requested period. It does this by cross-multiplying periods, so no reciprocal is ever formed. The ratio of frequency distances is computed by a four-step binary search. The result is clamped to 0..15 and mapped into the target's trim-field encoding. If the pulse stream stalls, an error flag is raised in place of a result.

Top module: `trim_cal_engine`

## Requirements
- R1: After reset, resultValid and errFlag are 0 and trimField is 0x8.
- R2: In calibration-pulse mode (preambleMode=0), the first rising edge after start arms the measurement. The next 2^AVG_LOG2 rising-edge-to-rising-edge intervals are summed, and the stored period is the sum shifted right by AVG_LOG2, which truncates any fraction.
- R3: In preamble mode (preambleMode=1), the elements are the widths (rise to fall) of the first 2^AVG_LOG2 high pulses after start. Any low header or data pulses that follow do not change the stored period.
- R4: pointSel=1 marks the fast point (trim -8) and pointSel=0 marks the slow point (trim +7). A start clears only the selected point's stored period, and the other point keeps its value.
- R5: A result is produced only when both points hold a completed measurement. With slow period Pl, fast period Ph and targetPeriod Pi (sampled when the computation begins), the index is q = floor(16*(Pl-Pi)*Ph / ((Pl-Ph)*Pi)), and resultValid is then set.
- R6: q is 0 when Pi >= Pl, and q is 15 when Pi <= Ph.
- R7: trimField = q XOR 0x8. This maps q=0 to trim +7 (written 0x8) and q=15 to trim -8 (written 0x7).
- R8: If no rising edge arrives within TIMEOUT_TICKS clock cycles of the start, or of the previous rising edge, while a measurement is running, errFlag is set, no result is produced, and the measurement is abandoned.
- R9: A start clears resultValid and errFlag in the next cycle and restarts measurement from any state. Otherwise resultValid, errFlag and trimField hold their values.
- R10: resultValid and errFlag are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all periods are counted in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a measurement |
| pointSel | input | 1 | 1 = fast (trim -8) point, 0 = slow (trim +7) point; sampled with start |
| preambleMode | input | 1 | 1 = measure high-pulse widths, 0 = measure rise-to-rise intervals; sampled with start |
| pulseIn | input | 1 | Asynchronous pulse stream from the target |
| targetPeriod | input | CNT_W | Desired time element in clock cycles |
| trimField | output | 4 | Encoded trim result |
| resultValid | output | 1 | trimField holds a fresh result |
| errFlag | output | 1 | Measurement abandoned on edge timeout |

## Verification
Corrupt state in this block shows at the ports only at the end of a measurement. A bad accumulator or element counter shows up as a wrong trimField one computation later. It can also show up as a result that never appears, which surfaces as errFlag after the timeout window. Stale per-point state shows up as a result that is produced when only one point has been re-measured after a failure. For this reason the tests re-measure single points and check that the other point is still used. Averages are chosen so that truncation and rounding lead to different codes. Target periods are placed exactly on both clamp boundaries.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_MEAS, ST_STORE, ST_INIT, ST_CALC
  } ctrlState_t;

  typedef struct packed {
    logic       tickClr;
    logic       accClr;
    logic       accAdd;
    logic       storeHigh;
    logic       storeLow;
    logic       searchInit;
    logic       searchStep;
    logic [1:0] stepBit;
  } dpCmd_t;
endpackage

// File: rtl/trim_cal_dp.sv
module trim_cal_dp
  import trim_cal_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int AVG_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseIn,
  input  logic [CNT_W-1:0] targetPeriod,
  input  dpCmd_t           cmd,
  output logic             rise,
  output logic             fall,
  output logic [CNT_W-1:0] tickCnt,
  output logic [3:0]       trimField
);
  localparam int ACC_W  = CNT_W + AVG_LOG2;
  localparam int PROD_W = 2 * CNT_W + 4;

  logic [2:0]       syncQ;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] pHigh, pLow, pIdeal;
  logic [3:0]       qReg, trial;
  logic             lockQ;
  logic [PROD_W-1:0] numProd, denProd, trialProd;

  // two synchroniser stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], pulseIn};
  end
  assign rise = syncQ[1] & ~syncQ[2];
  assign fall = ~syncQ[1] & syncQ[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tickCnt <= '0;
    else if (cmd.tickClr)     tickCnt <= CNT_W'(1);
    else if (tickCnt != '1)   tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            acc <= '0;
    else if (cmd.accClr)  acc <= '0;
    else if (cmd.accAdd)  acc <= acc + ACC_W'(tickCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pHigh <= '0;
      pLow  <= '0;
    end else begin
      if (cmd.storeHigh) pHigh <= acc[ACC_W-1:AVG_LOG2];
      if (cmd.storeLow)  pLow  <= acc[ACC_W-1:AVG_LOG2];
    end
  end

  // ratio of frequency distances expressed on periods
  assign numProd   = (PROD_W'(pLow - pIdeal) * PROD_W'(pHigh)) << 4;
  assign denProd   = PROD_W'(pLow - pHigh) * PROD_W'(pIdeal);
  assign trial     = qReg | (4'd1 << cmd.stepBit);
  assign trialProd = PROD_W'(trial) * denProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReg   <= '0;
      lockQ  <= 1'b0;
      pIdeal <= '0;
    end else if (cmd.searchInit) begin
      pIdeal <= targetPeriod;
      if (targetPeriod >= pLow) begin
        qReg  <= 4'd0;
        lockQ <= 1'b1;
      end else if (targetPeriod <= pHigh) begin
        qReg  <= 4'd15;
        lockQ <= 1'b1;
      end else begin
        qReg  <= 4'd0;
        lockQ <= 1'b0;
      end
    end else if (cmd.searchStep && !lockQ && (trialProd <= numProd)) begin
      qReg <= trial;
    end
  end

  assign trimField = {~qReg[3], qReg[2:0]};
endmodule

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
  import trim_cal_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int AVG_LOG2      = 3,
  parameter int TIMEOUT_TICKS = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             pointSel,
  input  logic             preambleMode,
  input  logic             rise,
  input  logic             fall,
  input  logic [CNT_W-1:0] tickCnt,
  output dpCmd_t           cmd,
  output logic             resultValid,
  output logic             errFlag
);
  localparam int NUM_ELEM = 1 << AVG_LOG2;
  localparam int EC_W     = AVG_LOG2 + 1;
  localparam logic [EC_W-1:0] LAST_ELEM = EC_W'(NUM_ELEM - 1);

  ctrlState_t      state;
  logic            ptHigh, preMode, haveHigh, haveLow;
  logic [EC_W-1:0] elemCnt;
  logic [1:0]      stepCnt;
  logic            elemEdge, timedOut;

  assign elemEdge = preMode ? fall : rise;
  assign timedOut = tickCnt >= CNT_W'(TIMEOUT_TICKS);

  always_comb begin
    cmd = '0;
    if (start) begin
      cmd.tickClr = 1'b1;
    end else begin
      unique case (state)
        ST_ARM:   if (rise) begin
                    cmd.tickClr = 1'b1;
                    cmd.accClr  = 1'b1;
                  end
        ST_MEAS:  begin
                    cmd.accAdd  = elemEdge;
                    cmd.tickClr = rise;
                  end
        ST_STORE: begin
                    cmd.storeHigh = ptHigh;
                    cmd.storeLow  = ~ptHigh;
                  end
        ST_INIT:  cmd.searchInit = 1'b1;
        ST_CALC:  begin
                    cmd.searchStep = 1'b1;
                    cmd.stepBit    = stepCnt;
                  end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      ptHigh      <= 1'b0;
      preMode     <= 1'b0;
      haveHigh    <= 1'b0;
      haveLow     <= 1'b0;
      elemCnt     <= '0;
      stepCnt     <= '0;
      resultValid <= 1'b0;
      errFlag     <= 1'b0;
    end else if (start) begin
      state       <= ST_ARM;
      ptHigh      <= pointSel;
      preMode     <= preambleMode;
      resultValid <= 1'b0;
      errFlag     <= 1'b0;
      if (pointSel) haveHigh <= 1'b0;
      else          haveLow  <= 1'b0;
    end else begin
      unique case (state)
        ST_ARM: begin
          if (rise) begin
            elemCnt <= '0;
            state   <= ST_MEAS;
          end else if (timedOut) begin
            errFlag <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_MEAS: begin
          if (elemEdge) elemCnt <= elemCnt + 1'b1;
          if (elemEdge && elemCnt == LAST_ELEM) begin
            state <= ST_STORE;
          end else if (!rise && timedOut) begin
            errFlag <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_STORE: begin
          if (ptHigh) haveHigh <= 1'b1;
          else        haveLow  <= 1'b1;
          state <= (ptHigh ? haveLow : haveHigh) ? ST_INIT : ST_IDLE;
        end
        ST_INIT: begin
          stepCnt <= 2'd3;
          state   <= ST_CALC;
        end
        ST_CALC: begin
          if (stepCnt == 2'd0) begin
            resultValid <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            stepCnt <= stepCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trim_cal_engine.sv
module trim_cal_engine
  import trim_cal_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int AVG_LOG2      = 3,
  parameter int TIMEOUT_TICKS = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             pointSel,
  input  logic             preambleMode,
  input  logic             pulseIn,
  input  logic [CNT_W-1:0] targetPeriod,
  output logic [3:0]       trimField,
  output logic             resultValid,
  output logic             errFlag
);
  dpCmd_t           cmd;
  logic             rise, fall;
  logic [CNT_W-1:0] tickCnt;

  trim_cal_ctrl #(
    .CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2), .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .pointSel(pointSel),
    .preambleMode(preambleMode), .rise(rise), .fall(fall),
    .tickCnt(tickCnt), .cmd(cmd), .resultValid(resultValid),
    .errFlag(errFlag)
  );

  trim_cal_dp #(
    .CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn),
    .targetPeriod(targetPeriod), .cmd(cmd), .rise(rise), .fall(fall),
    .tickCnt(tickCnt), .trimField(trimField)
  );
endmodule

// File: rtl/trim_cal_engine_chk.sv
module trim_cal_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [3:0] trimField,
  input logic       resultValid,
  input logic       errFlag
);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && errFlag));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!resultValid && !errFlag));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !start) |=> (resultValid && $stable(trimField)));

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !start) |=> errFlag);
endmodule

bind trim_cal_engine trim_cal_engine_chk chk_i (
  .clk(clk), .rstN(rstN), .start(start), .trimField(trimField),
  .resultValid(resultValid), .errFlag(errFlag)
);

// File: tb/trim_cal_engine_tb_top.sv
module trim_cal_engine_tb_top;
  localparam int CNT_W = 16;
  localparam int AVG_LOG2 = 3;
  localparam int TMO = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, pointSel = 1'b0, preambleMode = 1'b0, pulseIn = 1'b0;
  logic [CNT_W-1:0] targetPeriod = '0;
  logic [3:0] trimField;
  logic resultValid, errFlag;
  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trim_cal_engine #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2), .TIMEOUT_TICKS(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .pointSel(pointSel),
    .preambleMode(preambleMode), .pulseIn(pulseIn), .targetPeriod(targetPeriod),
    .trimField(trimField), .resultValid(resultValid), .errFlag(errFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected encoded field from the interpolation rule (R5, R6, R7)
  function automatic int expField(input longint pl, input longint ph, input longint pi);
    longint q;
    if (pi >= pl)      q = 0;
    else if (pi <= ph) q = 15;
    else begin
      q = (16 * (pl - pi) * ph) / ((pl - ph) * pi);
      if (q > 15) q = 15;
    end
    return int'(q) ^ 8;
  endfunction

  task automatic doStart(input logic sel, input logic pre);
    @(negedge clk);
    start = 1'b1; pointSel = sel; preambleMode = pre;
    @(negedge clk);
    start = 1'b0;
  endtask

  // nine rising edges; interval 7 is lengthened by extra
  task automatic calTrain(input int per, input int extra);
    for (int i = 0; i < 9; i++) begin
      pulseIn = 1'b1;
      repeat (per / 2) @(negedge clk);
      pulseIn = 1'b0;
      repeat (per - per / 2 + ((i == 7) ? extra : 0)) @(negedge clk);
    end
  endtask

  // twelve high pulses of te+/-wob, a long low header, then wide data pulses
  task automatic preTrain(input int te, input int wob);
    for (int i = 0; i < 12; i++) begin
      pulseIn = 1'b1;
      repeat (te + (((i % 2) == 0) ? wob : -wob)) @(negedge clk);
      pulseIn = 1'b0;
      repeat (te) @(negedge clk);
    end
    repeat (10 * te) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      pulseIn = 1'b1;
      repeat (3 * te) @(negedge clk);
      pulseIn = 1'b0;
      repeat (te) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 valid after reset", resultValid, 0);
    check("R1 err after reset", errFlag, 0);
    check("R1 field after reset", trimField, 8);
  endtask

  task automatic testFastOnly();
    doStart(1'b1, 1'b0);
    calTrain(40, 0);
    settle();
    check("R5 no result with one point", resultValid, 0);
    check("R5 no error with one point", errFlag, 0);
  endtask

  task automatic testInterpFloor();
    targetPeriod = 16'd55;
    doStart(1'b0, 1'b0);
    calTrain(60, 7);  // sum 487 -> truncated average 60 (R2)
    settle();
    check("R5 valid after both points", resultValid, 1);
    check("R2 truncating average / R7 field", trimField, expField(60, 40, 55));
  endtask

  task automatic testHold();
    targetPeriod = 16'd45;
    repeat (30) @(negedge clk);
    check("R9 field held without start", trimField, expField(60, 40, 55));
    check("R9 valid held", resultValid, 1);
  endtask

  task automatic testPreamble();
    targetPeriod = 16'd45;
    doStart(1'b1, 1'b1);
    check("R9 start clears valid", resultValid, 0);
    preTrain(40, 1);
    settle();
    check("R3 preamble valid", resultValid, 1);
    check("R3 R4 preamble width, slow point kept", trimField, expField(60, 40, 45));
  endtask

  task automatic remeasureSlow(input int pi, input string req);
    targetPeriod = CNT_W'(pi);
    doStart(1'b0, 1'b0);
    calTrain(60, 0);
    settle();
    check(req, trimField, expField(60, 40, pi));
  endtask

  task automatic testClamp();
    remeasureSlow(70, "R6 clamp low above slow period");
    check("R7 +7 end encoded as 8", trimField, 8);
    remeasureSlow(60, "R6 clamp low at slow period");
    remeasureSlow(35, "R6 clamp high below fast period");
    check("R7 -8 end encoded as 7", trimField, 7);
    remeasureSlow(40, "R6 clamp high at fast period");
    remeasureSlow(50, "R5 mid interpolation");
  endtask

  task automatic testTimeout();
    doStart(1'b0, 1'b0);
    repeat (TMO + 50) @(negedge clk);
    check("R8 error on no edge", errFlag, 1);
    check("R10 no valid with error", resultValid, 0);
    doStart(1'b0, 1'b0);
    check("R9 start clears error", errFlag, 0);
    for (int i = 0; i < 3; i++) begin
      pulseIn = 1'b1; repeat (30) @(negedge clk);
      pulseIn = 1'b0; repeat (30) @(negedge clk);
    end
    repeat (TMO + 50) @(negedge clk);
    check("R8 error on stall mid-train", errFlag, 1);
    check("R8 no result after stall", resultValid, 0);
    remeasureSlow(50, "R8 recovery after error");
    check("R8 error cleared on recovery", errFlag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testFastOnly();
    testInterpFloor();
    testHold();
    testPreamble();
    testClamp();
    testTimeout();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule